// File: doc/BRIEF.md
# Masked Register-Write Breakpoint Comparator

This block watches the stream of register writes leaving a CPU's execute stage and raises a break request when a write hits a chosen destination register with a chosen value. Debug logic programs three values: the register address to watch, a data pattern, and a bitwise mask. A mask bit set to one makes the matching pattern bit count in the comparison. A mask bit set to zero makes that bit a don't-care. A mask of all zeros turns the breakpoint into an address-only trigger that fires on any value written to the watched register. Only writes are compared. Register reads never reach this block.

The write port is a plain valid strobe with no ready signal. The CPU never stalls for the comparator, so every cycle with the strobe high is taken as one write. The break output is registered. It is high for one clock, one cycle after each qualifying write, and an enable input turns the whole comparator off. The data comparison is split into fixed-width lanes. The lane results are ANDed together, which keeps the reduction shallow for wide data.

Top module: `rwbp_watch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `brk_pulse` is 0.
- R2: A qualifying write presented in cycle N drives `brk_pulse` high in cycle N+1 only. Writes that qualify in consecutive cycles give consecutive high cycles, one per write.
- R3: A cycle with `wr_valid` low never produces a break, whatever the other inputs are.
- R4: While `bp_enable` is low, no break is produced, even for a write that would otherwise qualify.
- R5: A break requires `wr_addr` to equal `bp_addr` on every bit. A difference in any single address bit suppresses it.
- R6: For each data bit i where `bp_mask[i]` is 1, a break requires `wr_data[i]` to equal `bp_pattern[i]`.
- R7: For each data bit i where `bp_mask[i]` is 0, the value of `wr_data[i]` and `bp_pattern[i]` has no effect on the result.
- R8: With `bp_mask` all zeros, every valid write to the matching address breaks, whatever data is written.
- R9: With `bp_mask` all ones, a break happens only when `wr_data` equals `bp_pattern` exactly. A mismatch in any one bit position, in any lane, suppresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_enable | input | 1 | Enables the comparator |
| wr_valid | input | 1 | A register write is present this cycle |
| wr_addr | input | ADDR_W (8) | Destination register address of the write |
| wr_data | input | DATA_W (16) | Value being written |
| bp_addr | input | ADDR_W (8) | Watched register address |
| bp_pattern | input | DATA_W (16) | Data pattern to compare against |
| bp_mask | input | DATA_W (16) | Per-bit compare enable, 1 = compared |
| brk_pulse | output | 1 | Registered break request, one clock per qualifying write |

## Verification
The bench sweeps single-bit mismatches across every data and address position, with the mask both set and cleared at that bit. A comparator with a broken lane, a reversed mask polarity, or a dropped address bit would fire on one of these cases or stay silent on it. An all-zero mask is driven with varied data to catch logic that still compares unmasked bits. Back-to-back qualifying writes, and writes with the strobe or enable removed, expose an output that is stretched, merged, edge-detected or not gated. A behavioural model compares the output on every clock over a long biased random run.

// File: rtl/rwbp_pkg.sv
package rwbp_pkg;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_LANE_W = 4;

  function automatic int unsigned lane_count(input int unsigned data_w,
                                             input int unsigned lane_w);
    return (data_w + lane_w - 1) / lane_w;
  endfunction
endpackage

// File: rtl/rwbp_addr_cmp.sv
module rwbp_addr_cmp #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] watch_addr,
  output logic              addr_hit
);
  always_comb addr_hit = (dst_addr == watch_addr);
endmodule

// File: rtl/rwbp_data_cmp.sv
module rwbp_data_cmp
  import rwbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] mask,
  output logic              data_hit
);
  localparam int unsigned N_LANE = lane_count(DATA_W, LANE_W);
  localparam int unsigned PAD_W  = N_LANE * LANE_W;

  logic [PAD_W-1:0]  d_pad, p_pad, m_pad;
  logic [N_LANE-1:0] lane_ok;

  // Padding bits carry a zero mask, so they never affect the result.
  always_comb begin
    d_pad = '0;
    p_pad = '0;
    m_pad = '0;
    d_pad[DATA_W-1:0] = data;
    p_pad[DATA_W-1:0] = pattern;
    m_pad[DATA_W-1:0] = mask;
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    logic [LANE_W-1:0] diff;
    always_comb begin
      diff       = (d_pad[g*LANE_W +: LANE_W] ^ p_pad[g*LANE_W +: LANE_W])
                   & m_pad[g*LANE_W +: LANE_W];
      lane_ok[g] = ~|diff;
    end
  end

  always_comb data_hit = &lane_ok;
endmodule

// File: rtl/rwbp_watch.sv
module rwbp_watch
  import rwbp_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_enable,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [DATA_W-1:0] bp_pattern,
  input  logic [DATA_W-1:0] bp_mask,
  output logic              brk_pulse
);
  logic addr_hit, data_hit, fire;

  rwbp_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .dst_addr  (wr_addr),
    .watch_addr(bp_addr),
    .addr_hit  (addr_hit)
  );

  rwbp_data_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_data (
    .data    (wr_data),
    .pattern (bp_pattern),
    .mask    (bp_mask),
    .data_hit(data_hit)
  );

  always_comb fire = bp_enable & wr_valid & addr_hit & data_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= fire;
  end

  // R3
  brk_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(wr_valid));
  // R4
  brk_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(bp_enable));
  // R5
  brk_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(wr_addr == bp_addr));
  // R6
  brk_data_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(((wr_data ^ bp_pattern) & bp_mask) == '0));
  // R2
  brk_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_enable && wr_valid && wr_addr == bp_addr
     && ((wr_data ^ bp_pattern) & bp_mask) == '0) |=> brk_pulse);
  // R8
  brk_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_enable && wr_valid && wr_addr == bp_addr && bp_mask == '0) |=> brk_pulse);
endmodule

// File: tb/rwbp_watch_tb.sv
module rwbp_watch_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bp_enable = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] bp_addr = '0;
  logic [DW-1:0] bp_pattern = '0;
  logic [DW-1:0] bp_mask = '0;
  logic          brk_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rwbp_watch u_dut (
    .clk(clk), .rst_n(rst_n), .bp_enable(bp_enable), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .bp_addr(bp_addr),
    .bp_pattern(bp_pattern), .bp_mask(bp_mask), .brk_pulse(brk_pulse)
  );

  function automatic bit model(input bit en, input bit v,
                               input logic [AW-1:0] a, input logic [AW-1:0] ba,
                               input logic [DW-1:0] d, input logic [DW-1:0] p,
                               input logic [DW-1:0] m);
    bit ok;
    ok = en && v && (a == ba);
    for (int i = 0; i < DW; i++)
      if (m[i] && (d[i] != p[i])) ok = 0;
    return ok;
  endfunction

  task automatic check(input string req, input bit expv);
    n_chk++;
    if (brk_pulse !== expv) begin
      n_bad++;
      $display("FAIL %s: brk_pulse=%b expected=%b at %0t", req, brk_pulse, expv, $time);
    end
  endtask

  // Drive at negedge, let one posedge register it, compare at next negedge.
  task automatic apply(input string req, input bit en, input bit v,
                       input logic [AW-1:0] a, input logic [AW-1:0] ba,
                       input logic [DW-1:0] d, input logic [DW-1:0] p,
                       input logic [DW-1:0] m);
    bit e;
    bp_enable = en; wr_valid = v; wr_addr = a; bp_addr = ba;
    wr_data = d; bp_pattern = p; bp_mask = m;
    e = model(en, v, a, ba, d, p, m);
    @(negedge clk);
    check(req, e);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, even with a qualifying write held on the inputs
    bp_enable = 1; wr_valid = 1; wr_addr = 8'h1b; bp_addr = 8'h1b;
    check("R1", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_valid = 0;
    @(negedge clk);
    check("R1", 1'b0);

    // R2: single pulse, then back-to-back writes give consecutive pulses
    apply("R2", 1, 1, 8'h1b, 8'h1b, 16'hbeef, 16'hbeef, 16'hffff);
    apply("R2", 1, 0, 8'h1b, 8'h1b, 16'hbeef, 16'hbeef, 16'hffff);
    for (int k = 0; k < 3; k++)
      apply("R2", 1, 1, 8'h40, 8'h40, 16'h0000, 16'h1234, 16'h0000);
    apply("R2", 1, 0, 8'h40, 8'h40, 16'h0000, 16'h1234, 16'h0000);

    // R3: no valid strobe
    apply("R3", 1, 0, 8'h22, 8'h22, 16'h5555, 16'h5555, 16'hffff);
    // R4: enable low
    apply("R4", 0, 1, 8'h22, 8'h22, 16'h5555, 16'h5555, 16'hffff);
    apply("R4", 0, 1, 8'h22, 8'h22, 16'h0, 16'h0, 16'h0);

    // R5: one address bit off at each position
    for (int b = 0; b < AW; b++)
      apply("R5", 1, 1, 8'h5a ^ (8'h1 << b), 8'h5a, 16'h1111, 16'h1111, 16'hffff);

    // R6 / R7 / R9: single data bit flipped, mask bit set or cleared there
    for (int b = 0; b < DW; b++) begin
      apply("R9", 1, 1, 8'h33, 8'h33, 16'ha5c3 ^ (16'h1 << b), 16'ha5c3, 16'hffff);
      apply("R7", 1, 1, 8'h33, 8'h33, 16'ha5c3 ^ (16'h1 << b), 16'ha5c3,
            16'hffff ^ (16'h1 << b));
      apply("R6", 1, 1, 8'h33, 8'h33, 16'ha5c3 ^ (16'h1 << b), 16'ha5c3, 16'h1 << b);
    end
    apply("R9", 1, 1, 8'h33, 8'h33, 16'ha5c3, 16'ha5c3, 16'hffff);

    // R8: zero mask, varied data
    for (int k = 0; k < 8; k++)
      apply("R8", 1, 1, 8'h7e, 8'h7e, 16'($urandom), 16'($urandom), 16'h0000);
    apply("R8", 1, 1, 8'h7f, 8'h7e, 16'h0, 16'h0, 16'h0000);

    // R6: biased random run against the model
    for (int k = 0; k < 2000; k++) begin
      logic [AW-1:0] ba;
      logic [DW-1:0] p, m, d;
      ba = 8'($urandom);
      p  = 16'($urandom);
      case ($urandom % 4)
        0: m = 16'h0000;
        1: m = 16'hffff;
        default: m = 16'($urandom);
      endcase
      d = ($urandom % 2) ? (p ^ (16'($urandom) & ~m)) : 16'($urandom);
      apply("R6", ($urandom % 8) != 0, ($urandom % 4) != 0,
            ($urandom % 3) != 0 ? ba : 8'($urandom), ba, d, p, m);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule